// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two N-bit two's complement operands and returns their 2N-bit two's complement product. The multiplier operand is recoded into radix-4 signed digits, so N/2 partial-product rows are formed instead of N. Each digit picks zero, the multiplicand, or twice the multiplicand, with an optional negation. A tree of 3:2 carry-save compressors reduces the rows to two vectors, and a single carry-propagate adder adds those two vectors.

Each row's sign is handled with an inverted sign bit and a few constant ones instead of sign replication. The negation bit of each row except the last is placed in an empty low slot of the next row. The last row is formed directly as a two's complement value by a short dedicated incrementer, and the constant correction is folded into its two top bits. As a result the array has exactly N/2 rows, one fewer than the usual Booth arrangement. Operands are captured with a valid strobe. The product leaves through an optional output register.

Top module: `booth_mul`

## Requirements
- R1: For every pair of N-bit signed operands a and b, the product output equals a*b as a 2N-bit two's complement value. N is even and at least 4, and the default is 8.
- R2: With OUT_REG=1 the result appears with out_valid high exactly two clock cycles after the operands were accepted with in_valid high. With OUT_REG=0 it appears one cycle after. One result is produced per cycle, and results come out in the order the operands went in.
- R3: A synchronous active-high reset drives out_valid and the product output to zero. Operations that are in flight at the reset never produce a result.
- R4: Booth digit i is taken from multiplier bits 2i+1, 2i and 2i-1, with bit -1 read as 0. The digit value is -2*b[2i+1] + b[2i] + b[2i-1]. It selects the multiplicand, or the multiplicand shifted left by one, and never both. All eight bit patterns of every digit produce correct products.
- R5: The partial-product array holds exactly N/2 rows. The last row carries its own negation, and each earlier row's negation rides in the following row. Products are correct when only the top digit is negative, when it is -1 or the negative zero pattern 111, and when every digit is negative.
- R6: The extreme operands give exact results: (-2^(N-1))*(-2^(N-1)) = 2^(2N-2), (-2^(N-1))*(2^(N-1)-1), (-1)*(-1), and zero times any value.
- R7: While out_valid is low, the product output holds its last value.
- R8: Operand values presented while in_valid is low produce no result and do not disturb the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on a_i and b_i are taken this cycle |
| a_i | input | N | Multiplicand, two's complement |
| b_i | input | N | Multiplier (Booth-recoded), two's complement |
| out_valid | output | 1 | prod_o holds a new product |
| prod_o | output | 2N | Signed product |

## Verification
An exhaustive sweep of all 65536 operand pairs at N=8 is streamed back to back. It confirms the arithmetic and the one-per-cycle ordering. Directed multiplier patterns place each three-bit Booth window at every digit position, with the other bits zero. A faulty digit encoder or a misplaced negation bit therefore shows up at a known weight. Further patterns make only the top digit negative, or every digit negative, and these separate faults in the last row's incrementer and constant bits from faults in the earlier rows. Idle cycles with changing operands, and a reset issued behind an accepted operation, separate a correct hold and flush from a leak of stale or unrequested results.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  // Control of one recoded digit: value = (neg ? -1 : +1) * (one ? X : two ? 2X : 0)
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_sel_t;

  // Rows left after one level of 3:2 compression
  function automatic int rows_after(input int r);
    return 2 * (r / 3) + (r % 3);
  endfunction

  // Rows present at the input of a given level
  function automatic int rows_at(input int m, input int lvl);
    int r;
    r = m;
    for (int k = 0; k < lvl; k++) r = rows_after(r);
    return r;
  endfunction

  // Levels needed to reach two rows
  function automatic int tree_levels(input int m);
    int r;
    int l;
    r = m;
    l = 0;
    while (r > 2) begin
      r = rows_after(r);
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/booth_digit_enc.sv
module booth_digit_enc
  import booth_mul_pkg::*;
(
  input  logic [2:0] trip_i,
  output booth_sel_t sel_o
);

  always_comb begin
    sel_o.neg = trip_i[2];
    sel_o.one = trip_i[1] ^ trip_i[0];
    sel_o.two = (trip_i[2] & ~trip_i[1] & ~trip_i[0]) |
                (~trip_i[2] & trip_i[1] & trip_i[0]);
    // R4: a digit never selects both single and double multiple
    if (!$isunknown(trip_i)) begin
      a_r4_one_multiple: assert ($onehot0({sel_o.one, sel_o.two}));
    end
  end

endmodule

// File: rtl/booth_pp_array.sv
module booth_pp_array
  import booth_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]                 mcand_i,
  input  booth_sel_t [N/2-1:0]         sel_i,
  output logic [N/2-1:0][2*N-1:0]      rows_o
);

  localparam int M = N / 2;
  localparam int W = 2 * N;

  // Ones' complement multiples for rows 0 .. M-2 (N+1 bits, top bit is the sign)
  logic [M-2:0][N:0] body;

  for (genvar i = 0; i < M - 1; i++) begin : g_body
    logic [N:0] mag;
    assign mag = sel_i[i].one ? {mcand_i[N-1], mcand_i} :
                 sel_i[i].two ? {mcand_i, 1'b0} : '0;
    assign body[i] = mag ^ {(N+1){sel_i[i].neg}};
  end

  // Last row: true two's complement through its own short incrementer
  logic [N+1:0] last_mag;
  logic [N+1:0] last_val;
  assign last_mag = sel_i[M-1].one ? {{2{mcand_i[N-1]}}, mcand_i} :
                    sel_i[M-1].two ? {mcand_i[N-1], mcand_i, 1'b0} : '0;
  assign last_val = (last_mag ^ {(N+2){sel_i[M-1].neg}}) + (N+2)'(sel_i[M-1].neg);

  always_comb begin
    rows_o = '0;
    // Row 0: sign-prevention prefix s, s, ~s
    rows_o[0][N-1:0] = body[0][N-1:0];
    rows_o[0][N]     = body[0][N];
    rows_o[0][N+1]   = body[0][N];
    rows_o[0][N+2]   = ~body[0][N];
    // Middle rows: prefix 1, ~s and the previous row's negation bit
    for (int i = 1; i < M - 1; i++) begin
      rows_o[i][2*i +: N]    = body[i][N-1:0];
      rows_o[i][N+2*i]       = ~body[i][N];
      rows_o[i][N+2*i+1]     = 1'b1;
      rows_o[i][2*i-2]       = sel_i[i-1].neg;
    end
    // Last row: correction constant folded into its top two bits
    rows_o[M-1][N-2 +: N]  = last_val[N-1:0];
    rows_o[M-1][W-1 -: 2]  = last_val[N+1:N] - 2'd1;
    rows_o[M-1][N-4]       = sel_i[M-2].neg;
  end

endmodule

// File: rtl/booth_csa3.sv
module booth_csa3 #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);

  logic [W-1:0] maj;

  assign sum_o   = x_i ^ y_i ^ z_i;
  assign maj     = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
  assign carry_o = maj << 1;

endmodule

// File: rtl/booth_csa_tree.sv
module booth_csa_tree
  import booth_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N/2-1:0][2*N-1:0] rows_i,
  output logic [2*N-1:0]          sum_o,
  output logic [2*N-1:0]          carry_o
);

  localparam int M = N / 2;
  localparam int W = 2 * N;
  localparam int L = tree_levels(M);

  logic [W-1:0] stage [0:L][0:M-1];

  for (genvar r = 0; r < M; r++) begin : g_in
    assign stage[0][r] = rows_i[r];
  end

  for (genvar k = 0; k < L; k++) begin : g_lvl
    localparam int R  = rows_at(M, k);
    localparam int G  = R / 3;
    localparam int RN = rows_at(M, k + 1);
    for (genvar g = 0; g < G; g++) begin : g_csa
      booth_csa3 #(.W(W)) u_csa (
        .x_i    (stage[k][3*g]),
        .y_i    (stage[k][3*g+1]),
        .z_i    (stage[k][3*g+2]),
        .sum_o  (stage[k+1][2*g]),
        .carry_o(stage[k+1][2*g+1])
      );
    end
    for (genvar j = 0; j < R % 3; j++) begin : g_pass
      assign stage[k+1][2*G+j] = stage[k][3*G+j];
    end
    for (genvar r = RN; r < M; r++) begin : g_zero
      assign stage[k+1][r] = '0;
    end
  end

  assign sum_o   = stage[L][0];
  assign carry_o = stage[L][1];

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_mul_pkg::*;
#(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic           out_valid,
  output logic [2*N-1:0] prod_o
);

  localparam int M = N / 2;
  localparam int W = 2 * N;

  // Operand capture
  logic         v_q;
  logic [N-1:0] a_q;
  logic [N-1:0] b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
      a_q <= '0;
      b_q <= '0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        a_q <= a_i;
        b_q <= b_i;
      end
    end
  end

  // Phase 1: recoding and partial products
  booth_sel_t [M-1:0] sel;

  for (genvar d = 0; d < M; d++) begin : g_dig
    logic [2:0] trip;
    if (d == 0) begin : g_first
      assign trip = {b_q[1], b_q[0], 1'b0};
    end else begin : g_rest
      assign trip = b_q[2*d+1 -: 3];
    end
    booth_digit_enc u_enc (
      .trip_i(trip),
      .sel_o (sel[d])
    );
  end

  logic [M-1:0][W-1:0] rows;

  booth_pp_array #(.N(N)) u_pp (
    .mcand_i(a_q),
    .sel_i  (sel),
    .rows_o (rows)
  );

  // Phase 2: carry-save reduction
  logic [W-1:0] red_sum;
  logic [W-1:0] red_carry;

  booth_csa_tree #(.N(N)) u_tree (
    .rows_i (rows),
    .sum_o  (red_sum),
    .carry_o(red_carry)
  );

  // Phase 3: carry-propagate addition
  logic [W-1:0] prod_c;
  assign prod_c = red_sum + red_carry;

  // Reference product of the captured operands, for checking only
  logic [W-1:0] ref_p;
  assign ref_p = $signed({{N{a_q[N-1]}}, a_q}) * $signed({{N{b_q[N-1]}}, b_q});

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        prod_o    <= '0;
      end else begin
        out_valid <= v_q;
        if (v_q) prod_o <= prod_c;
      end
    end

    a_r1_product: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> prod_o == $past(ref_p));
    a_r2_latency_fwd: assert property (@(posedge clk) disable iff (rst)
      ($past(in_valid, 2) && !$past(rst, 2) && !$past(rst)) |-> out_valid);
    a_r2_latency_back: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid, 2));
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      (!out_valid && !$past(rst)) |-> $stable(prod_o));
  end else begin : g_comb
    assign out_valid = v_q;
    assign prod_o    = prod_c;

    a_r1_product: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> prod_o == ref_p);
    a_r2_latency_back: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid));
  end

  a_r3_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && prod_o == '0));

endmodule

// File: tb/booth_mul_bench.sv
`timescale 1ns/1ps
module booth_mul_bench;

  localparam int N = 8;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [N-1:0] a = '0;
  logic [N-1:0] b = '0;
  logic         out_valid;
  logic [W-1:0] prod;

  booth_mul #(.N(N), .OUT_REG(1'b1)) u_booth_mul (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .a_i      (a),
    .b_i      (b),
    .out_valid(out_valid),
    .prod_o   (prod)
  );

  always #2 clk = ~clk;

  int           n_tests = 0;
  int           n_fail  = 0;
  string        tag     = "R1";
  logic [W-1:0] expq[$];
  bit           done    = 1'b0;

  function automatic logic [W-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
    int p;
    p = int'($signed(x)) * int'($signed(y));
    return W'(p);
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Result monitor: every valid output is compared with the oldest expectation
  always @(negedge clk) begin : mon
    logic [W-1:0] e;
    if (!rst && out_valid) begin
      if (expq.size() == 0) begin
        check({tag, " unexpected out_valid"}, W'(1), W'(0));
      end else begin
        e = expq.pop_front();
        check(tag, prod, e);
      end
    end
  end

  task automatic send(input logic [N-1:0] x, input logic [N-1:0] y);
    @(negedge clk);
    in_valid = 1'b1;
    a = x;
    b = y;
    expq.push_back(ref_mul(x, y));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain;
    idle(4);
    check({tag, " all results seen"}, W'(expq.size()), W'(0));
  endtask

  task automatic t_reset;
    tag = "R3";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 reset out_valid", W'(out_valid), W'(0));
    check("R3 reset product", prod, W'(0));
    rst = 1'b0;
  endtask

  task automatic t_latency;
    tag = "R2";
    send(8'd3, 8'd5);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 no result after one cycle", W'(out_valid), W'(0));
    @(negedge clk);
    check("R2 result after two cycles", W'(out_valid), W'(1));
    drain();
  endtask

  task automatic t_corners;
    tag = "R6";
    send(8'h80, 8'h80);
    send(8'h80, 8'h7F);
    send(8'h7F, 8'h80);
    send(8'h7F, 8'h7F);
    send(8'hFF, 8'hFF);
    send(8'h00, 8'h80);
    send(8'h80, 8'h00);
    drain();
  endtask

  task automatic t_lastrow;
    logic [N-1:0] av [5] = '{8'h80, 8'h7F, 8'h01, 8'hFF, 8'h35};
    logic [N-1:0] bv [6] = '{8'h80, 8'hC0, 8'hE0, 8'hAA, 8'h40, 8'h60};
    tag = "R5";
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 6; j++)
        send(av[i], bv[j]);
    drain();
  endtask

  task automatic t_digits;
    tag = "R4";
    for (int d = 0; d < N / 2; d++) begin
      for (int t = 0; t < 8; t++) begin
        int bb;
        if (d == 0 && (t % 2) == 1) continue;
        bb = ((t >> 1) & 3) << (2 * d);
        if (d > 0) bb = bb | ((t & 1) << (2 * d - 1));
        send(8'h5B, N'(bb));
        send(8'h80, N'(bb));
      end
    end
    drain();
  endtask

  task automatic t_hold;
    logic [W-1:0] saved;
    tag = "R8";
    send(8'h7F, 8'h81);
    idle(3);
    saved = prod;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a = N'(k * 37 + 1);
      b = ~a;
      check("R7 product held while idle", prod, saved);
      check("R8 idle operands give no result", W'(out_valid), W'(0));
    end
  endtask

  task automatic t_flush;
    tag = "R3";
    @(negedge clk);
    in_valid = 1'b1;
    a = 8'h12;
    b = 8'h34;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R3 flush out_valid", W'(out_valid), W'(0));
    check("R3 flush product", prod, W'(0));
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R3 flushed operation never appears", W'(out_valid), W'(0));
    end
  endtask

  task automatic t_exhaustive;
    tag = "R1";
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        send(N'(i), N'(j));
    drain();
  endtask

  initial begin
    t_reset();
    t_latency();
    t_corners();
    t_lastrow();
    t_digits();
    t_hold();
    t_flush();
    t_exhaustive();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule